// File: doc/BRIEF.md
# Flash command interface controller

This block is a clock-synchronous model of the command front end of a word-wide flash memory. The host drives active-low chip enable, output enable, write enable and reset, an address and a 16-bit data word. Each write carries a command byte on data bits 7:0. The block decodes these bytes into a read mode, which picks what a read returns: stub array data taken from an input, an 8-bit status register padded to 16 bits, or one of two identifier codes.

A down-counter stands in for the program and erase engine. While it runs, the status register shows busy. An operation can be suspended and resumed. Four sticky error bits can be set by the engine and are cleared only by a dedicated command. The status value the host sees is captured when output enable or chip enable falls. A completion that happens during a long read therefore stays hidden until one of the enables is toggled.

The control pins are registered and edge-detected in the `clk_i` domain.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Writing 70h selects status mode. Every read then returns the status register for any address, until another command changes the mode.
- R2: In status mode, data_o[7:0] carries the status register and data_o[15:8] reads 00h. Status bit 7 is ready, bit 6 is erase suspended, bit 2 is program suspended, bits 5, 4, 3 and 1 are sticky, and bit 0 reads 0.
- R3: Starting a program or an erase switches the read mode to status automatically. Writing 40h or 20h also selects status mode while the second write is awaited.
- R4: Writing 90h selects identifier mode. Address bit 0 = 0 returns MFR_CODE and address bit 0 = 1 returns DEV_CODE. All other address bits are ignored.
- R5: Writing FFh selects array mode, in which data_o equals array_data_i. This is also the mode after reset.
- R6: Writing 50h clears status bits 1, 3, 4 and 5 and leaves the mode unchanged. Writing 20h and then any byte other than D0h sets bits 4 and 5. These bits stay set through other commands until 50h is written.
- R7: Writing B0h while an operation runs suspends it, so bit 7 becomes 1 together with bit 2 (program) or bit 6 (erase). Writing D0h while suspended clears that bit, returns bit 7 to 0, and the operation finishes its remaining cycles.
- R8: A suspended operation stays suspended through any enable-pin activity and through other commands. Only rst_ni low ends it, and that returns the whole block to status 80h and array mode.
- R9: The status value driven on the outputs is captured on a falling edge of oe_ni or ce_ni. A status change while both stay low is not visible until one of them is raised and lowered again.
- R10: A command is taken on the rising edge of we_ni only while ce_ni is low. A write-enable pulse with ce_ni high has no effect.
- R11: Writing 40h followed by any data word runs a program for PRG_CYCLES clocks. Writing 20h followed by D0h runs an erase for ERS_CYCLES clocks. Status bit 7 is 0 during the operation and 1 after it.
- R12: An unrecognised byte leaves the mode unchanged. While an operation runs, only 70h and B0h are accepted. data_o is 0 unless ce_ni and oe_ni are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, also the chip reset pin |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; command taken on its rising edge |
| addr_i | input | ADDR_W | Word address; only bit 0 matters (identifier mode) |
| data_i | input | 16 | Write data; bits 7:0 carry the command byte |
| array_data_i | input | 16 | Stub array read data |
| data_o | output | 16 | Read data |

## Verification
The bench sweeps all 256 command bytes from the reset state. A decoder that reacts to stray codes, or ignores a real one, then returns the wrong read source. Full address sweeps in identifier mode and status mode catch a design that decodes address bits other than bit 0. Holding both enables low across a whole program catches a transparent status path, which would show ready too early. Sequences for suspend, resume, sequence error, clear, and reset during a suspend catch the following faults: a suspend bit on the wrong operation, sticky bits that a mode change clears, and a suspend that an enable toggle or an unrelated command can end.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_PRG  = 2'd1,
    PEND_ERS  = 2'd2
  } pend_e;

  localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_RD_IDENT = 8'h90;
  localparam logic [7:0] OP_PRG_SET  = 8'h40;
  localparam logic [7:0] OP_ERS_SET  = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;

  localparam int unsigned NUM_PINS = 3;
  localparam int unsigned PIN_CE   = 0;
  localparam int unsigned PIN_OE   = 1;
  localparam int unsigned PIN_WE   = 2;
endpackage

// File: rtl/flash_pin_edge.sv
module flash_pin_edge #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_ni,
  output logic [WIDTH-1:0] lvl_no,
  output logic [WIDTH-1:0] fall_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] smp_q, dly_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q[i] <= 1'b1;
        dly_q[i] <= 1'b1;
      end else begin
        smp_q[i] <= pin_ni[i];
        dly_q[i] <= smp_q[i];
      end
    end
    assign fall_o[i] = dly_q[i] & ~smp_q[i];
    assign rise_o[i] = smp_q[i] & ~dly_q[i];
  end

  assign lvl_no = smp_q;
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
  parameter int unsigned PRG_CYCLES = 60,
  parameter int unsigned ERS_CYCLES = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_prg_i,
  input  logic       start_ers_i,
  input  logic       susp_req_i,
  input  logic       resume_i,
  input  logic       seq_err_i,
  input  logic       clr_i,
  output logic       running_o,
  output logic       suspended_o,
  output logic [7:0] status_o
);
  localparam int unsigned CNT_W = $clog2(PRG_CYCLES + ERS_CYCLES + 1);
  localparam logic [CNT_W-1:0] PRG_LAST = CNT_W'(PRG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERS_LAST = CNT_W'(ERS_CYCLES - 1);

  logic             busy_q, ers_q, susp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       stk_q;  // {b5, b4, b3, b1}

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ers_q  <= 1'b0;
      susp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_prg_i || start_ers_i) begin
      busy_q <= 1'b1;
      ers_q  <= start_ers_i;
      susp_q <= 1'b0;
      cnt_q  <= start_ers_i ? ERS_LAST : PRG_LAST;
    end else if (busy_q && !susp_q) begin
      if (susp_req_i)         susp_q <= 1'b1;
      else if (cnt_q == '0)   busy_q <= 1'b0;
      else                    cnt_q  <= cnt_q - 1'b1;
    end else if (busy_q && susp_q && resume_i) begin
      susp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stk_q <= '0;
    else if (seq_err_i) stk_q <= stk_q | 4'b1100;
    else if (clr_i)     stk_q <= '0;
  end

  assign running_o   = busy_q & ~susp_q;
  assign suspended_o = busy_q & susp_q;
  assign status_o    = {~busy_q | susp_q, susp_q & ers_q, stk_q[3], stk_q[2],
                        stk_q[1], susp_q & ~ers_q, stk_q[0], 1'b0};
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_vld_i,
  input  logic [7:0] cmd_i,
  input  logic     running_i,
  input  logic     suspended_i,
  output rd_mode_e mode_o,
  output logic     start_prg_o,
  output logic     start_ers_o,
  output logic     susp_req_o,
  output logic     resume_o,
  output logic     seq_err_o,
  output logic     clr_o
);
  rd_mode_e mode_q, mode_d;
  pend_e    pend_q, pend_d;

  always_comb begin
    mode_d      = mode_q;
    pend_d      = pend_q;
    start_prg_o = 1'b0;
    start_ers_o = 1'b0;
    susp_req_o  = 1'b0;
    resume_o    = 1'b0;
    seq_err_o   = 1'b0;
    clr_o       = 1'b0;
    if (cmd_vld_i) begin
      if (pend_q == PEND_PRG) begin
        start_prg_o = 1'b1;
        pend_d      = PEND_NONE;
        mode_d      = MODE_STATUS;
      end else if (pend_q == PEND_ERS) begin
        if (cmd_i == OP_CONFIRM) start_ers_o = 1'b1;
        else                     seq_err_o   = 1'b1;
        pend_d = PEND_NONE;
        mode_d = MODE_STATUS;
      end else if (running_i) begin
        if (cmd_i == OP_SUSPEND) begin
          susp_req_o = 1'b1;
          mode_d     = MODE_STATUS;
        end else if (cmd_i == OP_RD_STAT) begin
          mode_d = MODE_STATUS;
        end
      end else begin
        unique case (cmd_i)
          OP_RD_ARRAY: mode_d = MODE_ARRAY;
          OP_RD_STAT:  mode_d = MODE_STATUS;
          OP_RD_IDENT: mode_d = MODE_IDENT;
          OP_CLR_STAT: clr_o  = 1'b1;
          OP_PRG_SET: if (!suspended_i) begin
            pend_d = PEND_PRG;
            mode_d = MODE_STATUS;
          end
          OP_ERS_SET: if (!suspended_i) begin
            pend_d = PEND_ERS;
            mode_d = MODE_STATUS;
          end
          OP_CONFIRM: if (suspended_i) begin
            resume_o = 1'b1;
            mode_d   = MODE_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      pend_q <= PEND_NONE;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PRG_CYCLES = 60,
  parameter int unsigned ERS_CYCLES = 100,
  parameter logic [15:0] MFR_CODE   = 16'h00A7,
  parameter logic [15:0] DEV_CODE   = 16'h5C31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic [15:0]       array_data_i,
  output logic [15:0]       data_o
);
  logic [NUM_PINS-1:0] pin_lvl_n, pin_fall, pin_rise;
  logic       cmd_vld;
  logic       start_prg, start_ers, susp_req, resume, seq_err, clr;
  logic       running, suspended;
  logic [7:0] status_w, stat_lat_q;
  logic       lat_evt, rd_en;
  rd_mode_e   mode;
  logic       unused_in;

  flash_pin_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni ({we_ni, oe_ni, ce_ni}),
    .lvl_no (pin_lvl_n),
    .fall_o (pin_fall),
    .rise_o (pin_rise)
  );

  assign cmd_vld = pin_rise[PIN_WE] & ~pin_lvl_n[PIN_CE];

  flash_cmd_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_vld_i   (cmd_vld),
    .cmd_i       (data_i[7:0]),
    .running_i   (running),
    .suspended_i (suspended),
    .mode_o      (mode),
    .start_prg_o (start_prg),
    .start_ers_o (start_ers),
    .susp_req_o  (susp_req),
    .resume_o    (resume),
    .seq_err_o   (seq_err),
    .clr_o       (clr)
  );

  flash_wsm #(.PRG_CYCLES(PRG_CYCLES), .ERS_CYCLES(ERS_CYCLES)) u_wsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_prg_i (start_prg),
    .start_ers_i (start_ers),
    .susp_req_i  (susp_req),
    .resume_i    (resume),
    .seq_err_i   (seq_err),
    .clr_i       (clr),
    .running_o   (running),
    .suspended_o (suspended),
    .status_o    (status_w)
  );

  assign lat_evt = pin_fall[PIN_OE] | pin_fall[PIN_CE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_lat_q <= 8'h80;
    else if (lat_evt) stat_lat_q <= status_w;
  end

  assign rd_en = ~pin_lvl_n[PIN_CE] & ~pin_lvl_n[PIN_OE];

  always_comb begin
    data_o = '0;
    if (rd_en) begin
      unique case (mode)
        MODE_STATUS: data_o = {8'h00, stat_lat_q};
        MODE_IDENT:  data_o = addr_i[0] ? DEV_CODE : MFR_CODE;
        default:     data_o = array_data_i;
      endcase
    end
  end

  // Only address bit 0 and the command byte are decoded.
  assign unused_in = ^{addr_i[ADDR_W-1:1], data_i[15:8]};
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_en,
  input rd_mode_e    mode,
  input logic [15:0] data_o,
  input logic [7:0]  status_w,
  input logic [7:0]  stat_lat_q,
  input logic        lat_evt,
  input logic        clr,
  input logic        start_prg,
  input logic        start_ers
);
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && mode == MODE_STATUS) |-> data_o[15:8] == 8'h00); // R2

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prg || start_ers) |=> !status_w[7]); // R11

  AST_SUSP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w[2] || status_w[6]) |-> status_w[7]); // R7

  AST_SUSP_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({status_w[2], status_w[6]})); // R7

  AST_CLEAR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (status_w & 8'h3A) == 8'h00); // R6

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_evt |=> $stable(stat_lat_q)); // R9

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |-> data_o == 16'h0000); // R12
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en      (rd_en),
  .mode       (mode),
  .data_o     (data_o),
  .status_w   (status_w),
  .stat_lat_q (stat_lat_q),
  .lat_evt    (lat_evt),
  .clr        (clr),
  .start_prg  (start_prg),
  .start_ers  (start_ers)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned PRG_CYC    = 60;
  localparam int unsigned ERS_CYC    = 100;
  localparam logic [15:0] MFR        = 16'h00A7;
  localparam logic [15:0] DEV        = 16'h5C31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] din = '0, arr = 16'h0000, dout;
  int checks = 0, errors = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .PRG_CYCLES(PRG_CYC), .ERS_CYCLES(ERS_CYC),
                   .MFR_CODE(MFR), .DEV_CODE(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .array_data_i(arr), .data_o(dout));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w, input logic ce_lvl);
    @(negedge clk); ce_n = ce_lvl; din = w;
    repeat (2) @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] r);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk); r = dout;
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    arr = 16'hBEEF;
    check("R12 idle bus", dout, 16'h0000);
    rd(8'h00, v); check("R5 reset array mode", v, 16'hBEEF);

    // R12: oe high with ce low keeps bus at zero
    @(negedge clk); ce_n = 1'b0; repeat (4) @(negedge clk);
    check("R12 oe high", dout, 16'h0000); ce_n = 1'b1; repeat (2) @(negedge clk);

    // Sweep every command byte from reset (R1 R3 R4 R5 R12)
    for (int c = 0; c < 256; c++) begin
      logic [15:0] exp;
      do_reset();
      arr = {8'(c), ~8'(c)};
      wr({8'h00, 8'(c)}, 1'b0);
      case (8'(c))
        8'h70, 8'h40, 8'h20: exp = 16'h0080;
        8'h90: exp = c[0] ? DEV : MFR;
        default: exp = arr;
      endcase
      rd(8'(c), v); check("R1/R3/R4/R5/R12 cmd sweep", v, exp);
    end

    // R4 identifier: full address sweep
    do_reset(); wr(16'h0090, 1'b0);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v); check("R4 ident addr", v, a[0] ? DEV : MFR);
    end
    // R1 status: full address sweep
    wr(16'h0070, 1'b0);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v); check("R1 status addr", v, 16'h0080);
    end
    wr(16'h00FF, 1'b0); rd(8'h00, v); check("R5 back to array", v, arr);

    // R10: write with ce high ignored
    wr(16'h0090, 1'b1); rd(8'h00, v); check("R10 ce high", v, arr);

    // R11/R3 program; R9 latch held across completion
    do_reset(); wr(16'h0040, 1'b0); wr(16'h1234, 1'b0);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk); check("R11 program busy", dout, 16'h0000);
    repeat (PRG_CYC + 20) @(negedge clk);
    check("R9 stale status", dout, 16'h0000);
    oe_n = 1'b1; repeat (3) @(negedge clk); oe_n = 1'b0; repeat (4) @(negedge clk);
    check("R9 refreshed on oe", dout, 16'h0080);
    ce_n = 1'b1; oe_n = 1'b1; repeat (2) @(negedge clk);

    // R12: commands ignored while running
    wr(16'h0020, 1'b0); wr(16'h00D0, 1'b0);
    rd(8'h00, v); check("R11 erase busy", v, 16'h0000);
    wr(16'h00FF, 1'b0); rd(8'h01, v); check("R12 busy ignores FF", v, 16'h0000);
    repeat (ERS_CYC) @(negedge clk);
    rd(8'h00, v); check("R11 erase done", v, 16'h0080);

    // R6 sequence error and clear
    wr(16'h0020, 1'b0); wr(16'h0033, 1'b0);
    rd(8'h00, v); check("R6 seq error", v, 16'h00B0);
    wr(16'h00FF, 1'b0); wr(16'h0070, 1'b0);
    rd(8'h00, v); check("R6 sticky kept", v, 16'h00B0);
    wr(16'h0050, 1'b0);
    rd(8'h00, v); check("R6 cleared, mode kept", v, 16'h0080);

    // R7/R8 erase suspend and resume
    wr(16'h0020, 1'b0); wr(16'h00D0, 1'b0); wr(16'h00B0, 1'b0);
    rd(8'h00, v); check("R7 erase suspended", v, 16'h00C0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); ce_n = k[0]; oe_n = k[1];
      repeat (30) @(negedge clk);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    wr(16'h0040, 1'b0); wr(16'h0070, 1'b0);
    rd(8'h00, v); check("R8 still suspended", v, 16'h00C0);
    wr(16'h00FF, 1'b0); rd(8'h00, v); check("R8 array while suspended", v, arr);
    wr(16'h00D0, 1'b0);
    rd(8'h00, v); check("R7 resumed busy", v, 16'h0000);
    repeat (ERS_CYC) @(negedge clk);
    rd(8'h00, v); check("R7 resumed completes", v, 16'h0080);

    // R7/R8 program suspend then reset
    wr(16'h0040, 1'b0); wr(16'h5555, 1'b0); wr(16'h00B0, 1'b0);
    rd(8'h00, v); check("R7 program suspended", v, 16'h0084);
    do_reset();
    rd(8'h00, v); check("R8 reset to array", v, arr);
    wr(16'h0070, 1'b0);
    rd(8'h00, v); check("R8 reset status", v, 16'h0080);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule